// File: doc/BRIEF.md
# Serial Flash Command Validator

This block is the slave-side command front end of a serial NOR flash. It works off a fast system clock and samples the serial clock, chip select and data input as ordinary synchronous inputs. While chip select is low it assembles the incoming bits into bytes and keeps a bit phase and a byte count. When chip select rises it checks the framing of the captured command. If the framing is legal it fires a one-cycle execute pulse to the internal controller, together with the opcode, the address, the status byte or the data length.

Read-type commands switch the block into a data-out phase. Array reads fetch bytes through a simple address/data port. Status reads and identification reads serve bytes that the block forms itself. Page-program data bytes are streamed to a staging port as they arrive. The controller commits them only when the execute pulse follows. While the controller reports busy, commands that touch the array or the status register are dropped.

Top module: `flash_cmd_front`

## Requirements
- R1: Bits are taken MSB first on each rising `sck_i` edge while `csn_i` is low; the first eight bits form the opcode and bytes 2..4 form the 24-bit address, high byte first.
- R2: Opcodes 0x06, 0x04, 0x01, 0x02, 0xD8, 0xC7, 0xB9 and 0xAB run only when the bit count at the rising edge of `csn_i` is a nonzero multiple of eight. A run is a single-cycle `exec_o` one clock after `csn_i` rises, with `exec_cmd_o` equal to the opcode.
- R3: 0x06 sets `wel_o` and 0x04 clears it. 0x01, 0x02, 0xD8 and 0xC7 need `wel_o`=1 and `busy_i`=0 at frame end, and clear `wel_o` when they run.
- R4: 0xD8 runs only with exactly four bytes in the frame, and `exec_addr_o` carries its address.
- R5: 0x02 runs only with at least five bytes, and `exec_len_o` gives the number of data bytes. A short or partial-byte 0x02 frame leaves `wel_o` unchanged.
- R6: Each data byte of a 0x02 frame, from the fifth byte on, gives a one-cycle `pg_we_o`. `pg_idx_o` carries the data index modulo 2^PG_W and `pg_data_o` carries the byte.
- R7: 0x01 needs at least two bytes, and `exec_sr_o` carries the second byte.
- R8: `sdo_o` changes only after a falling `sck_i` edge. Output is MSB first, and the first bit follows the fall after the last input bit. `sdo_en_o` is 0 whenever `csn_i` is 1.
- R9: 0x03 outputs array bytes after the address. 0x0B outputs them after one more dummy byte. The address advances per byte and wraps from 0xFFFFFF to 0. The byte for `rd_addr_o` is taken from `rd_data_i`.
- R10: 0x05 outputs `{sr_hi_i, wel, busy_i}` repeatedly, with the value re-formed for each byte.
- R11: 0xAB outputs DEV_ID repeatedly after three dummy bytes. 0x90 outputs MFR_ID and DEV_ID alternately after three address bytes; it starts with MFR_ID when address bit 0 is 0 and with DEV_ID otherwise.
- R12: If `busy_i` is 1 when the opcode completes, 0x03 and 0x0B leave `sdo_en_o` at 0. While busy, writes are refused, but 0x05 still answers.
- R13: Raising `csn_i` after any output bit stops output at once, and the next frame decodes from scratch.
- R14: The byte count saturates at 2^CNT_W-1 and never wraps, so an overlong 0xD8 frame is never taken as a four-byte frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial clock (idle low) |
| csn_i | input | 1 | Chip select, active low |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_en_o | output | 1 | Output drive enable |
| busy_i | input | 1 | Controller busy with a write/erase cycle |
| sr_hi_i | input | 6 | Upper status bits from the controller |
| rd_addr_o | output | 24 | Array read address |
| rd_data_i | input | 8 | Array read data |
| wel_o | output | 1 | Write-enable latch |
| exec_o | output | 1 | Execute pulse |
| exec_cmd_o | output | 8 | Opcode of executed command |
| exec_addr_o | output | 24 | Address of executed command |
| exec_sr_o | output | 8 | Status byte for a status write |
| exec_len_o | output | CNT_W | Program data byte count |
| pg_we_o | output | 1 | Staging write strobe |
| pg_idx_o | output | PG_W | Staging byte index |
| pg_data_o | output | 8 | Staging byte |

## Verification
The bench builds the block with CNT_W=4, so the byte counter saturates at 15. A 20-byte erase frame then shows that saturation does not alias to a legal count. PG_W=2 makes the staging index wrap after four data bytes, so a six-byte program shows the index folding back. MFR_ID=0x1C and DEV_ID=0x15 are distinct values, so the order of the alternating identification bytes can be seen. Each serial clock half period lasts four system clocks, which leaves room for the array fetch between the address latch and the first output fall.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_FAST = 8'h0B;
  localparam logic [7:0] OP_PP   = 8'h02;
  localparam logic [7:0] OP_SE   = 8'hD8;
  localparam logic [7:0] OP_BE   = 8'hC7;
  localparam logic [7:0] OP_DP   = 8'hB9;
  localparam logic [7:0] OP_RES  = 8'hAB;
  localparam logic [7:0] OP_RDID = 8'h90;

  typedef enum logic [2:0] {
    RM_NONE, RM_ARRAY, RM_STAT, RM_DEV, RM_IDPAIR
  } rd_mode_e;
endpackage

// File: rtl/flash_cmd_rx.sv
module flash_cmd_rx #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sck_i,
  input  logic             csn_i,
  input  logic             sdi_i,
  output logic             sck_fall_o,
  output logic             frame_end_o,
  output logic [2:0]       bit_ph_o,
  output logic [CNT_W-1:0] byte_cnt_o,
  output logic             byte_vld_o,
  output logic [7:0]       byte_o,
  output logic [CNT_W-1:0] byte_idx_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic       sck_q, csn_q, sck_rise;
  logic [6:0] sh_q;

  assign sck_rise    = sck_i & ~sck_q & ~csn_i;
  assign sck_fall_o  = ~sck_i & sck_q & ~csn_i;
  assign frame_end_o = csn_i & ~csn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q      <= 1'b0;
      csn_q      <= 1'b1;
      sh_q       <= '0;
      bit_ph_o   <= '0;
      byte_cnt_o <= '0;
      byte_vld_o <= 1'b0;
      byte_o     <= '0;
      byte_idx_o <= '0;
    end else begin
      sck_q      <= sck_i;
      csn_q      <= csn_i;
      byte_vld_o <= 1'b0;
      if (csn_i) begin
        bit_ph_o   <= '0;
        byte_cnt_o <= '0;
      end else if (sck_rise) begin
        sh_q     <= {sh_q[5:0], sdi_i};
        bit_ph_o <= bit_ph_o + 3'd1;
        if (bit_ph_o == 3'd7) begin
          byte_o     <= {sh_q, sdi_i};
          byte_vld_o <= 1'b1;
          byte_idx_o <= byte_cnt_o;
          // saturate so overlong frames never alias to a legal count
          if (byte_cnt_o != CNT_MAX) byte_cnt_o <= byte_cnt_o + 1'b1;
        end
      end
    end
  end

  assert_cnt_no_wrap_R14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_cnt_o == CNT_MAX) |=> (byte_cnt_o == CNT_MAX || byte_cnt_o == '0));

  assert_byte_on_rise_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |-> !$past(csn_i) && $past(sck_i));
endmodule

// File: rtl/flash_cmd_ctl.sv
module flash_cmd_ctl
  import flash_cmd_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int PG_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             csn_i,
  input  logic             busy_i,
  input  logic             frame_end_i,
  input  logic [2:0]       bit_ph_i,
  input  logic [CNT_W-1:0] byte_cnt_i,
  input  logic             byte_vld_i,
  input  logic [7:0]       byte_i,
  input  logic [CNT_W-1:0] byte_idx_i,
  output logic             wel_o,
  output logic             exec_o,
  output logic [7:0]       exec_cmd_o,
  output logic [23:0]      exec_addr_o,
  output logic [7:0]       exec_sr_o,
  output logic [CNT_W-1:0] exec_len_o,
  output logic             pg_we_o,
  output logic [PG_W-1:0]  pg_idx_o,
  output logic [7:0]       pg_data_o,
  output rd_mode_e         rd_mode_o,
  output logic [2:0]       rd_start_o,
  output logic [23:0]      addr_o,
  output logic             addr_done_o
);
  localparam logic [CNT_W-1:0] N_SR = CNT_W'(2);
  localparam logic [CNT_W-1:0] N_SE = CNT_W'(4);
  localparam logic [CNT_W-1:0] N_PP = CNT_W'(5);
  localparam logic [CNT_W-1:0] HDR  = CNT_W'(4);

  logic [7:0]       op_q, sr_q;
  logic             op_vld_q;
  logic             aligned, wr_ok, accept;
  logic [CNT_W-1:0] data_idx;
  rd_mode_e         mode_d;
  logic [2:0]       start_d;

  assign aligned  = op_vld_q && (bit_ph_i == 3'd0);
  assign wr_ok    = wel_o && !busy_i;
  assign data_idx = byte_idx_i - HDR;

  always_comb begin
    unique case (op_q)
      OP_WREN, OP_WRDI, OP_DP, OP_RES: accept = aligned;
      OP_WRSR: accept = aligned && wr_ok && (byte_cnt_i >= N_SR);
      OP_PP:   accept = aligned && wr_ok && (byte_cnt_i >= N_PP);
      OP_SE:   accept = aligned && wr_ok && (byte_cnt_i == N_SE);
      OP_BE:   accept = aligned && wr_ok;
      default: accept = 1'b0;
    endcase
  end

  always_comb begin
    start_d = 3'd4;
    unique case (byte_i)
      OP_READ: mode_d = busy_i ? RM_NONE : RM_ARRAY;
      OP_FAST: begin mode_d = busy_i ? RM_NONE : RM_ARRAY; start_d = 3'd5; end
      OP_RDSR: begin mode_d = RM_STAT; start_d = 3'd1; end
      OP_RES:  mode_d = RM_DEV;
      OP_RDID: mode_d = RM_IDPAIR;
      default: mode_d = RM_NONE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q        <= '0;
      op_vld_q    <= 1'b0;
      sr_q        <= '0;
      addr_o      <= '0;
      addr_done_o <= 1'b0;
      rd_mode_o   <= RM_NONE;
      rd_start_o  <= '0;
      pg_we_o     <= 1'b0;
      pg_idx_o    <= '0;
      pg_data_o   <= '0;
    end else begin
      addr_done_o <= 1'b0;
      pg_we_o     <= 1'b0;
      if (csn_i) begin
        op_vld_q  <= 1'b0;
        rd_mode_o <= RM_NONE;
      end else if (byte_vld_i) begin
        if (byte_idx_i == '0) begin
          op_q       <= byte_i;
          op_vld_q   <= 1'b1;
          rd_mode_o  <= mode_d;
          rd_start_o <= start_d;
        end
        if (byte_idx_i == CNT_W'(1)) begin
          addr_o[23:16] <= byte_i;
          sr_q          <= byte_i;
        end
        if (byte_idx_i == CNT_W'(2)) addr_o[15:8] <= byte_i;
        if (byte_idx_i == CNT_W'(3)) begin
          addr_o[7:0] <= byte_i;
          addr_done_o <= 1'b1;
        end
        if (op_vld_q && op_q == OP_PP && byte_idx_i >= HDR) begin
          pg_we_o   <= 1'b1;
          pg_idx_o  <= data_idx[PG_W-1:0];
          pg_data_o <= byte_i;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_o       <= 1'b0;
      exec_o      <= 1'b0;
      exec_cmd_o  <= '0;
      exec_addr_o <= '0;
      exec_sr_o   <= '0;
      exec_len_o  <= '0;
    end else begin
      exec_o <= frame_end_i && accept;
      if (frame_end_i && accept) begin
        exec_cmd_o  <= op_q;
        exec_addr_o <= addr_o;
        exec_sr_o   <= sr_q;
        exec_len_o  <= (op_q == OP_PP) ? byte_cnt_i - HDR : '0;
        unique case (op_q)
          OP_WREN: wel_o <= 1'b1;
          OP_WRDI, OP_WRSR, OP_PP, OP_SE, OP_BE: wel_o <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  assert_exec_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_o |=> !exec_o);

  assert_exec_after_cs_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_o |-> $past(csn_i) && !$past(csn_i, 2));

  assert_wr_needs_wel_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_o && (exec_cmd_o == OP_PP || exec_cmd_o == OP_SE ||
                exec_cmd_o == OP_BE || exec_cmd_o == OP_WRSR))
      |-> $past(wel_o) && !$past(busy_i) && !wel_o);

  assert_se_four_bytes_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_o && exec_cmd_o == OP_SE) |-> $past(byte_cnt_i) == N_SE);

  assert_pg_only_pp_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pg_we_o |-> op_q == OP_PP);
endmodule

// File: rtl/flash_cmd_tx.sv
module flash_cmd_tx
  import flash_cmd_pkg::*;
#(
  parameter int         CNT_W  = 12,
  parameter logic [7:0] MFR_ID = 8'h1C,
  parameter logic [7:0] DEV_ID = 8'h15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sck_i,
  input  logic             csn_i,
  input  logic             sck_fall_i,
  input  logic [2:0]       bit_ph_i,
  input  logic [CNT_W-1:0] byte_cnt_i,
  input  rd_mode_e         mode_i,
  input  logic [2:0]       start_i,
  input  logic [23:0]      addr_i,
  input  logic             addr_done_i,
  input  logic [7:0]       rd_data_i,
  input  logic [5:0]       sr_hi_i,
  input  logic             wel_i,
  input  logic             busy_i,
  output logic [23:0]      rd_addr_o,
  output logic             sdo_o,
  output logic             sdo_en_o
);
  logic [7:0] out_q, nxt;
  logic       en_q, id_sel_q, load;

  assign load = sck_fall_i && mode_i != RM_NONE && bit_ph_i == 3'd0 &&
                byte_cnt_i >= CNT_W'(start_i);

  always_comb begin
    unique case (mode_i)
      RM_ARRAY:  nxt = rd_data_i;
      RM_STAT:   nxt = {sr_hi_i, wel_i, busy_i};
      RM_DEV:    nxt = DEV_ID;
      RM_IDPAIR: nxt = id_sel_q ? DEV_ID : MFR_ID;
      default:   nxt = 8'h00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q     <= '0;
      en_q      <= 1'b0;
      id_sel_q  <= 1'b0;
      rd_addr_o <= '0;
    end else if (csn_i) begin
      en_q <= 1'b0;
    end else if (addr_done_i) begin
      rd_addr_o <= addr_i;
      id_sel_q  <= addr_i[0];
    end else if (load) begin
      out_q <= nxt;
      en_q  <= 1'b1;
      if (mode_i == RM_ARRAY)  rd_addr_o <= rd_addr_o + 24'd1;
      if (mode_i == RM_IDPAIR) id_sel_q  <= ~id_sel_q;
    end else if (sck_fall_i && en_q) begin
      out_q <= {out_q[6:0], 1'b0};
    end
  end

  assign sdo_o    = out_q[7];
  assign sdo_en_o = en_q & ~csn_i;

  assert_sdo_on_fall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && $past(en_q) && !$past(sck_fall_i)) |-> $stable(out_q[7]));

  assert_en_rise_on_fall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdo_en_o) |-> !$past(sck_i) && $past(sck_i, 2));

  assert_busy_no_read_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && busy_i) |-> mode_i != RM_ARRAY || en_q || $past(en_q));
endmodule

// File: rtl/flash_cmd_front.sv
module flash_cmd_front
  import flash_cmd_pkg::*;
#(
  parameter int         CNT_W  = 12,
  parameter int         PG_W   = 8,
  parameter logic [7:0] MFR_ID = 8'h1C,
  parameter logic [7:0] DEV_ID = 8'h15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sck_i,
  input  logic             csn_i,
  input  logic             sdi_i,
  output logic             sdo_o,
  output logic             sdo_en_o,
  input  logic             busy_i,
  input  logic [5:0]       sr_hi_i,
  output logic [23:0]      rd_addr_o,
  input  logic [7:0]       rd_data_i,
  output logic             wel_o,
  output logic             exec_o,
  output logic [7:0]       exec_cmd_o,
  output logic [23:0]      exec_addr_o,
  output logic [7:0]       exec_sr_o,
  output logic [CNT_W-1:0] exec_len_o,
  output logic             pg_we_o,
  output logic [PG_W-1:0]  pg_idx_o,
  output logic [7:0]       pg_data_o
);
  logic             sck_fall, frame_end, byte_vld, addr_done;
  logic [2:0]       bit_ph, rd_start;
  logic [CNT_W-1:0] byte_cnt, byte_idx;
  logic [7:0]       byte_val;
  logic [23:0]      addr;
  rd_mode_e         rd_mode;

  flash_cmd_rx #(.CNT_W(CNT_W)) u_rx (
    .clk_i, .rst_ni, .sck_i, .csn_i, .sdi_i,
    .sck_fall_o(sck_fall), .frame_end_o(frame_end), .bit_ph_o(bit_ph),
    .byte_cnt_o(byte_cnt), .byte_vld_o(byte_vld), .byte_o(byte_val),
    .byte_idx_o(byte_idx)
  );

  flash_cmd_ctl #(.CNT_W(CNT_W), .PG_W(PG_W)) u_ctl (
    .clk_i, .rst_ni, .csn_i, .busy_i,
    .frame_end_i(frame_end), .bit_ph_i(bit_ph), .byte_cnt_i(byte_cnt),
    .byte_vld_i(byte_vld), .byte_i(byte_val), .byte_idx_i(byte_idx),
    .wel_o, .exec_o, .exec_cmd_o, .exec_addr_o, .exec_sr_o, .exec_len_o,
    .pg_we_o, .pg_idx_o, .pg_data_o,
    .rd_mode_o(rd_mode), .rd_start_o(rd_start), .addr_o(addr),
    .addr_done_o(addr_done)
  );

  flash_cmd_tx #(.CNT_W(CNT_W), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_tx (
    .clk_i, .rst_ni, .sck_i, .csn_i,
    .sck_fall_i(sck_fall), .bit_ph_i(bit_ph), .byte_cnt_i(byte_cnt),
    .mode_i(rd_mode), .start_i(rd_start), .addr_i(addr),
    .addr_done_i(addr_done), .rd_data_i, .sr_hi_i, .wel_i(wel_o), .busy_i,
    .rd_addr_o, .sdo_o, .sdo_en_o
  );
endmodule

// File: tb/sim_flash_cmd_front.sv
module sim_flash_cmd_front;
  localparam int CNT_W = 4;
  localparam int PG_W  = 2;
  localparam int H     = 4;
  localparam logic [7:0] MFR = 8'h1C;
  localparam logic [7:0] DEV = 8'h15;

  // {op[31:24], nbits[23:12], unused, wel_pre[2], exp_exec[1], exp_wel[0]}
  localparam int NV = 18;
  localparam logic [31:0] VEC [NV] = '{
    {8'h06, 12'd8,  9'd0, 3'b011},  // R2 WREN
    {8'h06, 12'd9,  9'd0, 3'b000},  // R2 misaligned
    {8'h04, 12'd8,  9'd0, 3'b110},  // R3 WRDI
    {8'hD8, 12'd32, 9'd0, 3'b110},  // R4 exact
    {8'hD8, 12'd24, 9'd0, 3'b101},  // R4 short
    {8'hD8, 12'd40, 9'd0, 3'b101},  // R4 long
    {8'hD8, 12'd33, 9'd0, 3'b101},  // R2 misaligned
    {8'h02, 12'd40, 9'd0, 3'b110},  // R5 minimal
    {8'h02, 12'd32, 9'd0, 3'b101},  // R5 no data
    {8'h02, 12'd43, 9'd0, 3'b101},  // R5 partial
    {8'h02, 12'd40, 9'd0, 3'b000},  // R3 no latch
    {8'h01, 12'd16, 9'd0, 3'b110},  // R7
    {8'h01, 12'd8,  9'd0, 3'b101},  // R7 short
    {8'hC7, 12'd8,  9'd0, 3'b110},  // R3 BE
    {8'hC7, 12'd8,  9'd0, 3'b000},  // R3 BE no latch
    {8'hB9, 12'd8,  9'd0, 3'b010},  // R2 DP
    {8'hB9, 12'd12, 9'd0, 3'b000},  // R2 DP misaligned
    {8'hFF, 12'd8,  9'd0, 3'b000}   // unknown opcode
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, csn = 1'b1, sdi = 1'b0, force_busy = 1'b0;
  logic [5:0] sr_hi = 6'b101101;
  logic sdo, sdo_en, busy, wel, exec, pg_we;
  logic [23:0] rd_addr, exec_addr;
  logic [7:0]  rd_data, exec_cmd, exec_sr, pg_data;
  logic [CNT_W-1:0] exec_len;
  logic [PG_W-1:0]  pg_idx;

  int total = 0, bad = 0, exec_cnt = 0, pg_cnt = 0, busy_cnt = 0;
  logic [7:0] last_cmd, last_sr, last_pg_data;
  logic [23:0] last_addr;
  logic [CNT_W-1:0] last_len;
  logic [PG_W-1:0] last_pg_idx;
  logic [7:0] rx [8];
  logic seen_en;
  bit done = 0;

  always #10 clk = ~clk;

  function automatic logic [7:0] stub(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
  endfunction
  assign rd_data = stub(rd_addr);
  assign busy = (busy_cnt != 0) | force_busy;

  flash_cmd_front #(.CNT_W(CNT_W), .PG_W(PG_W), .MFR_ID(MFR), .DEV_ID(DEV)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .csn_i(csn), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_en_o(sdo_en), .busy_i(busy), .sr_hi_i(sr_hi),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data), .wel_o(wel), .exec_o(exec),
    .exec_cmd_o(exec_cmd), .exec_addr_o(exec_addr), .exec_sr_o(exec_sr),
    .exec_len_o(exec_len), .pg_we_o(pg_we), .pg_idx_o(pg_idx),
    .pg_data_o(pg_data)
  );

  // busy-timer stub and event monitors
  always @(posedge clk) begin
    if (rst_n && exec) begin
      exec_cnt  <= exec_cnt + 1;
      last_cmd  <= exec_cmd;
      last_addr <= exec_addr;
      last_sr   <= exec_sr;
      last_len  <= exec_len;
      if (exec_cmd inside {8'h02, 8'hD8, 8'hC7, 8'h01}) busy_cnt <= 40;
    end else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
    if (rst_n && pg_we) begin
      pg_cnt <= pg_cnt + 1;
      last_pg_idx  <= pg_idx;
      last_pg_data <= pg_data;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pb(input int j);
    if (j == 0) return 8'h12;
    if (j == 1) return 8'h34;
    if (j == 2) return 8'h56;
    return 8'hA0 + 8'(j);
  endfunction

  task automatic xfer_bit(input logic b, output logic o);
    @(negedge clk) sdi = b;
    repeat (H) @(negedge clk);
    o = sdo;
    if (sdo_en) seen_en = 1'b1;
    sck = 1'b1;
    repeat (H) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic cs_low();
    @(negedge clk) csn = 1'b0;
    seen_en = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic cs_high();
    repeat (H) @(negedge clk);
    csn = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] v);
    logic o;
    for (int i = 7; i >= 0; i--) xfer_bit(v[i], o);
  endtask

  task automatic run_frame(input logic [7:0] op, input int nbits);
    logic o;
    cs_low();
    for (int i = 0; i < nbits; i++) begin
      logic [7:0] pv;
      if (i < 8) xfer_bit(op[7-i], o);
      else begin
        pv = pb((i - 8) / 8);
        xfer_bit(pv[7 - ((i - 8) % 8)], o);
      end
    end
    cs_high();
  endtask

  task automatic read_frame(input logic [7:0] op, input logic [23:0] a,
                            input int ndum, input int n);
    logic o;
    cs_low();
    send_byte(op);
    send_byte(a[23:16]); send_byte(a[15:8]); send_byte(a[7:0]);
    for (int d = 0; d < ndum; d++) send_byte(8'h00);
    for (int k = 0; k < n; k++)
      for (int i = 7; i >= 0; i--) begin
        xfer_bit(1'b0, o);
        rx[k][i] = o;
      end
    cs_high();
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic set_wel(input logic w);
    if (w && !wel) run_frame(8'h06, 8);
    if (!w && wel) run_frame(8'h04, 8);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=0", 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int e0;
    logic o;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // reset state
    chk(!sdo_en && !wel && exec_cnt == 0, "reset R8 R3", {sdo_en, wel}, 0);

    // vector table: R2 R3 R4 R5 R7
    for (int v = 0; v < NV; v++) begin
      wait_idle();
      set_wel(VEC[v][2]);
      wait_idle();
      e0 = exec_cnt;
      run_frame(VEC[v][31:24], int'(VEC[v][23:12]));
      chk((exec_cnt - e0) == int'(VEC[v][1]), $sformatf("vec%0d exec R2", v),
          exec_cnt - e0, VEC[v][1]);
      chk(wel == VEC[v][0], $sformatf("vec%0d wel R3", v), wel, VEC[v][0]);
      if (VEC[v][1])
        chk(last_cmd == VEC[v][31:24], $sformatf("vec%0d cmd R2", v),
            last_cmd, VEC[v][31:24]);
    end

    // R1 R4: address MSB first
    wait_idle(); set_wel(1); e0 = exec_cnt;
    run_frame(8'hD8, 32);
    chk(last_addr == 24'h123456 && exec_cnt == e0 + 1, "R1 R4 se addr",
        last_addr, 24'h123456);

    // R7: status byte
    wait_idle(); set_wel(1);
    run_frame(8'h01, 16);
    chk(last_sr == 8'h12, "R7 sr byte", last_sr, 8'h12);

    // R5 R6: program with six data bytes, page index wraps at 4
    wait_idle(); set_wel(1); e0 = pg_cnt;
    run_frame(8'h02, 80);
    chk(pg_cnt - e0 == 6, "R6 stage count", pg_cnt - e0, 6);
    chk(last_pg_idx == 2'd1, "R6 idx wrap", last_pg_idx, 1);
    chk(last_pg_data == 8'hA8, "R6 data", last_pg_data, 8'hA8);
    chk(last_len == 4'd6, "R5 len", last_len, 6);

    // R14: 20-byte erase must not alias to four bytes
    wait_idle(); set_wel(1); e0 = exec_cnt;
    run_frame(8'hD8, 160);
    chk(exec_cnt == e0 && wel, "R14 saturate", exec_cnt - e0, 0);

    // R9: read with wrap
    wait_idle();
    read_frame(8'h03, 24'hFFFFFE, 0, 3);
    chk(rx[0] == stub(24'hFFFFFE), "R9 read0 R8", rx[0], stub(24'hFFFFFE));
    chk(rx[1] == stub(24'hFFFFFF), "R9 read1", rx[1], stub(24'hFFFFFF));
    chk(rx[2] == stub(24'h000000), "R9 wrap", rx[2], stub(24'h000000));
    chk(!sdo_en, "R8 hiz after cs", sdo_en, 0);

    // R9: fast read with dummy byte
    read_frame(8'h0B, 24'h000010, 1, 2);
    chk(rx[0] == stub(24'h10) && rx[1] == stub(24'h11), "R9 fast",
        {rx[0], rx[1]}, {stub(24'h10), stub(24'h11)});

    // R11
    read_frame(8'hAB, 24'h000000, 0, 2);
    chk(rx[0] == DEV && rx[1] == DEV, "R11 res id", {rx[0], rx[1]}, {DEV, DEV});
    read_frame(8'h90, 24'h000000, 0, 2);
    chk(rx[0] == MFR && rx[1] == DEV, "R11 id pair even", {rx[0], rx[1]}, {MFR, DEV});
    read_frame(8'h90, 24'h000001, 0, 2);
    chk(rx[0] == DEV && rx[1] == MFR, "R11 id pair odd", {rx[0], rx[1]}, {DEV, MFR});

    // R10 R12: status while busy, reads and writes refused
    wait_idle(); set_wel(1);
    force_busy = 1'b1;
    cs_low();
    send_byte(8'h05);
    for (int k = 0; k < 2; k++)
      for (int i = 7; i >= 0; i--) begin xfer_bit(1'b0, o); rx[k][i] = o; end
    cs_high();
    chk(rx[0] == 8'hB7 && rx[1] == 8'hB7, "R10 R12 status", {rx[0], rx[1]}, 16'hB7B7);
    read_frame(8'h03, 24'h000020, 0, 1);
    chk(!seen_en, "R12 read while busy", seen_en, 0);
    e0 = exec_cnt;
    run_frame(8'hD8, 32);
    chk(exec_cnt == e0 && wel, "R12 erase while busy", exec_cnt - e0, 0);
    force_busy = 1'b0;

    // R13: cs rises mid-output, next frame clean
    cs_low();
    send_byte(8'h03); send_byte(8'h00); send_byte(8'h00); send_byte(8'h00);
    for (int i = 0; i < 3; i++) xfer_bit(1'b0, o);
    chk(sdo_en, "R13 output active", sdo_en, 1);
    cs_high();
    chk(!sdo_en, "R13 stop", sdo_en, 0);
    cs_low();
    send_byte(8'h05);
    for (int i = 7; i >= 0; i--) begin xfer_bit(1'b0, o); rx[0][i] = o; end
    cs_high();
    chk(rx[0] == 8'hB6, "R13 fresh frame R10", rx[0], 8'hB6);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule